// File: doc/BRIEF.md
# Absolute Position Serial Frame Transmitter

This block is the slave end of a synchronous serial link that reports an absolute shaft position. It joins two position fields into one word: a multi-turn revolution count and a single-turn angle, each with its own width parameter. An external master clocks the word out. The block samples the master clock into its own system clock domain through a synchroniser and watches that clock for edges. On the first falling edge of a burst it captures both fields in a single cycle and raises the strobe. On each later rising edge it puts the next bit on the data line. The revolution count goes first and the angle follows; each field is sent most-significant bit first.

Two inputs choose the coding. One converts each field to Gray code on its own before the two are joined. The other reverses the counting sense by inverting the first bit of the frame. Both are sampled with the positions at the capture point.

A frame ends when the master clock rests high, with no edge, for a set number of system cycles. The strobe then falls and the next burst captures fresh positions. While the strobe is low the data line is held high.

Top module: `ssi_pos_tx`

## Requirements
- R1: While reset is held and just after it is released, `strobe` is 0 and `sdata` is 1.
- R2: The falling edge of `sclk_in` that starts a frame is seen at the output three system cycles after the change: `strobe` goes to 1 and all inputs are captured. `sdata` stays 1 until the next rising edge.
- R3: Each rising edge of `sclk_in` while `strobe` is 1 puts the next frame bit on `sdata`, three system cycles after the change. The frame is MT_W+ST_W bits long. Frame bit 0 is `mt_pos[MT_W-1]`, the multi-turn bits follow down to bit 0, and then come `st_pos[ST_W-1]` down to bit 0.
- R4: Once the last frame bit has been sent, further rising edges drive `sdata` to 1. `sdata` is 1 whenever `strobe` is 0.
- R5: With `gray_en`=1 each field is sent as g = b XOR (b >> 1), computed within that field only. With `gray_en`=0 each field is sent as plain binary.
- R6: With `dir_inv`=1 the first frame bit, the multi-turn MSB after coding, is inverted. No other bit changes.
- R7: Changes to `mt_pos`, `st_pos`, `gray_en` or `dir_inv` after the capture point have no effect on the frame in progress.
- R8: `strobe` falls only after IDLE_CYC consecutive system cycles with no synchronised `sclk_in` edge and the clock level high. A shorter pause leaves the frame running.
- R9: A burst that stops before the last bit ends in the same way once the gap has elapsed. The next burst captures new data and starts again at frame bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Master serial clock, asynchronous, rests high |
| mt_pos | input | MT_W | Multi-turn revolution count, binary |
| st_pos | input | ST_W | Single-turn angle, binary |
| gray_en | input | 1 | 1 selects Gray coding of each field |
| dir_inv | input | 1 | 1 inverts the first frame bit |
| sdata | output | 1 | Serial data to the master |
| strobe | output | 1 | 1 while a captured word is locked |

## Verification
The hardest cases to reach depend on how the master clock is timed against the idle gap. The first is a pause inside a frame that is just shorter than the gap and must not end it. The second is a burst cut off after a few bits, which must end and then start over cleanly at frame bit 0 with new data. The bench's master task can hold the clock high for a chosen number of cycles after any bit, or stop a burst after any number of bits. It can also change the position inputs partway through a frame. A per-cycle reference model tracks the synchroniser delay and the gap count, so each of these runs is checked cycle by cycle.

// File: rtl/ssi_pos_pkg.sv
package ssi_pos_pkg;
  // Binary to Gray on a zero-extended field; upper zeros keep the field's own MSB.
  function automatic logic [31:0] code_field(input logic [31:0] v, input logic gray);
    return gray ? (v ^ (v >> 1)) : v;
  endfunction
endpackage

// File: rtl/ssi_clk_sync.sv
module ssi_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic fall_evt,
  output logic rise_evt
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];

  assign lvl      = chain[STAGES-1];
  assign fall_evt = prev & ~lvl;
  assign rise_evt = ~prev & lvl;
endmodule

// File: rtl/ssi_gap_timer.sv
module ssi_gap_timer #(
  parameter int IDLE_CYC = 640
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic edge_seen,
  input  logic lvl,
  output logic expire
);
  localparam int CNT_W = $clog2(IDLE_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 cnt <= '0;
    else if (!active || edge_seen) cnt <= '0;
    else if (cnt != LIMIT)      cnt <= cnt + 1'b1;

  assign expire = active && !edge_seen && lvl && (cnt == LIMIT);
endmodule

// File: rtl/ssi_frame_shift.sv
module ssi_frame_shift #(
  parameter int FW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] word,
  input  logic          shift,
  input  logic          clear,
  output logic          dout,
  output logic [$clog2(FW+1)-1:0] bits_left
);
  localparam int LEFT_W = $clog2(FW + 1);
  localparam logic [LEFT_W-1:0] FULL = LEFT_W'(FW);

  logic [FW-1:0] sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr        <= '0;
      bits_left <= '0;
      dout      <= 1'b1;
    end else if (load) begin
      sr        <= word;
      bits_left <= FULL;
      dout      <= 1'b1;
    end else if (clear) begin
      bits_left <= '0;
      dout      <= 1'b1;
    end else if (shift) begin
      if (bits_left != '0) begin
        dout      <= sr[FW-1];
        sr        <= {sr[FW-2:0], 1'b0};
        bits_left <= bits_left - 1'b1;
      end else begin
        dout      <= 1'b1;
      end
    end
endmodule

// File: rtl/ssi_pos_tx.sv
module ssi_pos_tx
  import ssi_pos_pkg::*;
#(
  parameter int MT_W        = 14,
  parameter int ST_W        = 12,
  parameter int IDLE_CYC    = 640,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_in,
  input  logic [MT_W-1:0] mt_pos,
  input  logic [ST_W-1:0] st_pos,
  input  logic            gray_en,
  input  logic            dir_inv,
  output logic            sdata,
  output logic            strobe
);
  localparam int FW     = MT_W + ST_W;
  localparam int LEFT_W = $clog2(FW + 1);

  logic              sclk_lvl, fall_evt, rise_evt;
  logic              active_q, gap_expire, load, shift;
  logic [MT_W-1:0]   mt_code;
  logic [ST_W-1:0]   st_code;
  logic [FW-1:0]     word;
  logic [LEFT_W-1:0] bits_left;

  ssi_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sclk_in),
    .lvl(sclk_lvl), .fall_evt(fall_evt), .rise_evt(rise_evt)
  );

  ssi_gap_timer #(.IDLE_CYC(IDLE_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .active(active_q),
    .edge_seen(fall_evt | rise_evt), .lvl(sclk_lvl), .expire(gap_expire)
  );

  // Each field coded on its own, then joined; direction flips the frame MSB.
  assign mt_code = MT_W'(code_field(32'(mt_pos), gray_en));
  assign st_code = ST_W'(code_field(32'(st_pos), gray_en));
  assign word    = {mt_code ^ {dir_inv, {(MT_W-1){1'b0}}}, st_code};

  assign load  = fall_evt & ~active_q;
  assign shift = rise_evt & active_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          active_q <= 1'b0;
    else if (load)       active_q <= 1'b1;
    else if (gap_expire) active_q <= 1'b0;

  ssi_frame_shift #(.FW(FW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .word(word),
    .shift(shift), .clear(gap_expire), .dout(sdata), .bits_left(bits_left)
  );

  assign strobe = active_q;
endmodule

// File: rtl/ssi_pos_tx_chk.sv
module ssi_pos_tx_chk #(
  parameter int FW = 26
) (
  input logic clk,
  input logic rst_n,
  input logic strobe,
  input logic sdata,
  input logic fall_evt,
  input logic rise_evt,
  input logic sclk_lvl,
  input logic [$clog2(FW+1)-1:0] bits_left
);
  p_lock_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $past(fall_evt));

  p_full_count_on_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> (bits_left == ($clog2(FW+1))'(FW)));

  p_idle_line_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> sdata);

  p_hold_between_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe) && !$past(rise_evt)) |-> $stable(sdata));

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bits_left <= ($clog2(FW+1))'(FW));

  p_quiet_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> ($past(sclk_lvl) && !$past(fall_evt) && !$past(rise_evt)));
endmodule

bind ssi_pos_tx ssi_pos_tx_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .sdata(sdata),
  .fall_evt(fall_evt), .rise_evt(rise_evt), .sclk_lvl(sclk_lvl),
  .bits_left(bits_left)
);

// File: tb/tb_ssi_pos_tx.sv
`timescale 1ns/1ps
module tb_ssi_pos_tx;
  localparam int MT_W = 14;
  localparam int ST_W = 12;
  localparam int FW   = MT_W + ST_W;
  localparam int IDLE = 48;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_in = 1'b1;
  logic [MT_W-1:0] mt_pos = '0;
  logic [ST_W-1:0] st_pos = '0;
  logic gray_en = 1'b0;
  logic dir_inv = 1'b0;
  logic sdata, strobe;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";
  bit cap [0:63];

  always #2.5 clk = ~clk;

  ssi_pos_tx #(.MT_W(MT_W), .ST_W(ST_W), .IDLE_CYC(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .mt_pos(mt_pos),
    .st_pos(st_pos), .gray_en(gray_en), .dir_inv(dir_inv),
    .sdata(sdata), .strobe(strobe)
  );

  // Expected frame, built bit by bit from the requirements.
  function automatic longint exp_frame(input int mt, input int st, input bit g, input bit inv);
    longint f = 0;
    for (int i = MT_W - 1; i >= 0; i--) begin
      int b = (mt >> i) & 1;
      int up = (i == MT_W - 1) ? 0 : ((mt >> (i + 1)) & 1);
      f = f * 2 + (g ? (b ^ up) : b);
    end
    for (int i = ST_W - 1; i >= 0; i--) begin
      int b = (st >> i) & 1;
      int up = (i == ST_W - 1) ? 0 : ((st >> (i + 1)) & 1);
      f = f * 2 + (g ? (b ^ up) : b);
    end
    if (inv) f = f ^ (longint'(1) << (FW - 1));
    return f;
  endfunction

  // Behavioural reference: serial clock seen through a 3-sample history.
  bit     hq[$];
  bit     m_act, m_dout;
  int     m_left, m_idle;
  longint m_word;

  always @(posedge clk) begin
    if (!rst_n) begin
      hq = '{1'b1, 1'b1, 1'b1};
      m_act = 0; m_dout = 1; m_left = 0; m_idle = 0; m_word = 0;
    end else begin
      bit fell, rose, high;
      fell = hq[0] && !hq[1];
      rose = !hq[0] && hq[1];
      high = hq[1];
      if (!m_act) begin
        if (fell) begin
          m_act = 1; m_left = FW; m_idle = 0;
          m_word = exp_frame(int'(mt_pos), int'(st_pos), gray_en, dir_inv);
        end
      end else if (fell || rose) begin
        m_idle = 0;
        if (rose) begin
          if (m_left > 0) begin
            m_dout = bit'((m_word >> (m_left - 1)) & 1);
            m_left--;
          end else m_dout = 1;
        end
      end else if (m_idle == IDLE && high) begin
        m_act = 0; m_dout = 1; m_left = 0;
      end else if (m_idle < IDLE) m_idle++;
      void'(hq.pop_front());
      hq.push_back(sclk_in);
    end
  end

  always @(negedge clk) begin
    compared++;
    if (sdata !== m_dout || strobe !== m_act) begin
      mismatched++;
      $display("FAIL %s cycle compare: sdata=%b strobe=%b expected sdata=%b strobe=%b",
               cur_req, sdata, strobe, m_dout, m_act);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Master burst: a falling edge to capture, then nclk rise/fall pairs, sampling on falls.
  task automatic burst(input int nclk, input int pause_after, input int change_after);
    sclk_in = 1'b0;
    wait_cyc(HALF);
    for (int k = 1; k <= nclk; k++) begin
      sclk_in = 1'b1;
      wait_cyc(HALF);
      if (k == pause_after) wait_cyc(IDLE - 8);
      cap[k] = sdata;
      if (k == change_after) begin
        mt_pos = ~mt_pos; st_pos = ~st_pos; gray_en = ~gray_en; dir_inv = ~dir_inv;
      end
      sclk_in = 1'b0;
      wait_cyc(HALF);
    end
    sclk_in = 1'b1;
    wait_cyc(IDLE + 12);
  endtask

  task automatic check_frame(input string req, input int nclk, input longint exp);
    longint got = 0, want = 0;
    for (int k = 1; k <= nclk; k++) begin
      got  = got * 2 + longint'(cap[k]);
      want = want * 2 + ((k <= FW) ? ((exp >> (FW - k)) & 1) : 1);
    end
    check(req, got, want);
  endtask

  task automatic run(input string req, input int mt, input int st, input bit g, input bit inv,
                     input int nclk, input int pause_after, input int change_after);
    longint e;
    cur_req = req;
    mt_pos = MT_W'(mt); st_pos = ST_W'(st); gray_en = g; dir_inv = inv;
    e = exp_frame(mt, st, g, inv);
    burst(nclk, pause_after, change_after);
    check_frame(req, nclk, e);
    check({req, " strobe low after gap R8"}, longint'(strobe), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait_cyc(5);
    check("R1 reset strobe", longint'(strobe), 0);
    check("R1 reset sdata", longint'(sdata), 1);
    rst_n = 1'b1;
    wait_cyc(4);
    check("R1 after release", longint'({strobe, sdata}), 1);

    run("R2 R3 binary",        14'h2A5C, 12'h9E1, 0, 0, FW, 0, 0);
    run("R3 zeros",            0, 0, 0, 0, FW, 0, 0);
    run("R3 ones",             14'h3FFF, 12'hFFF, 0, 0, FW, 0, 0);
    run("R5 gray",             14'h1234, 12'hABC, 1, 0, FW, 0, 0);
    run("R5 gray ones",        14'h3FFF, 12'hFFF, 1, 0, FW, 0, 0);
    run("R6 direction",        14'h0F0F, 12'h5A5, 0, 1, FW, 0, 0);
    run("R6 R5 both",          14'h2001, 12'h801, 1, 1, FW, 0, 0);
    run("R7 change mid frame", 14'h1357, 12'h246, 0, 0, FW, 6, 6);
    run("R4 extra clocks",     14'h0001, 12'h003, 0, 0, FW + 4, 0, 0);
    run("R8 pause inside",     14'h2C3A, 12'h71E, 1, 0, FW, 10, 0);
    run("R9 short burst",      14'h3333, 12'hCCC, 0, 0, 5, 0, 0);
    run("R9 fresh after cut",  14'h0AAA, 12'h555, 0, 1, FW, 0, 0);

    // R2: strobe must already be up three cycles after the capturing fall.
    cur_req = "R2";
    sclk_in = 1'b0;
    wait_cyc(3);
    check("R2 strobe three cycles after fall", longint'(strobe), 1);
    check("R2 sdata high before first rise", longint'(sdata), 1);
    wait_cyc(HALF);
    sclk_in = 1'b1;
    wait_cyc(IDLE + 12);
    check("R8 strobe low after final gap", longint'(strobe), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule